// File: doc/BRIEF.md
# Performance-State Voltage/Frequency Sequencer

This controller moves one clock-and-supply domain between a fixed ladder of operating points. Each point pairs a voltage code with a frequency code. The voltage code goes to an external supply regulator and the frequency code goes to an external clock generator. Software or a policy engine posts a requested point index. The sequencer then applies the two codes in an order that keeps timing safe. The voltage comes up before the clock speeds up, and the clock slows down before the voltage drops. Every voltage move waits for the regulator to report that it has settled.

Point index 0 is the fastest regular point, and each larger index is slower and draws less power. A reserved index selects a boost point above the regular maximum. The boost point is entered only while two inputs are both high: one says power is under budget and one says temperature is under its limit. If either input falls while the domain is boosted, the sequencer pulls the domain back to point 0. It returns to boost once both inputs are high again and the boost request is still pending. The operating-point codes are computed from parameters inside the block, so no table has to be loaded.

Top module: `dvfs_seq`

## Requirements
- R1: The regular point with index k (k from 0 to NUM_PSTATES-1) drives freq_code = FREQ_TOP - FREQ_STEP*(k+1) and volt_code = VOLT_TOP - VOLT_STEP*(k+1). The all-ones index selects boost, which drives freq_code = FREQ_TOP and volt_code = VOLT_TOP. cur_idx reports the point in force, using the same encoding.
- R2: On a move to a faster point, volt_code changes first. freq_code changes only on the clock edge that samples vreg_settled high, and at that point the move completes.
- R3: On a move to a slower point, freq_code changes first. volt_code changes on the next clock edge. The move completes on the edge that samples vreg_settled high. The two codes never change on the same edge.
- R4: Between a voltage change and the sampled settle pulse, both codes hold their values and busy stays high.
- R5: Boost is entered only while pwr_ok and temp_ok are both high. A boost request made while either input is low is served as point 0. The request stays pending, so boost is entered later once both inputs are high.
- R6: If pwr_ok or temp_ok is low while boost is in force, the sequencer starts a move to point 0 on the next edge, using the slower-point ordering.
- R7: busy is high from the start of a move until it completes. A request posted (req_valid high) during a move is held and is carried out after the move completes. The last request posted wins.
- R8: A request for the point already in force changes neither code and does not raise busy.
- R9: Indices from NUM_PSTATES up to one below all-ones are treated as the slowest regular point, NUM_PSTATES-1.
- R10: After reset, the domain sits at the slowest regular point with busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Posts req_idx as the new target point |
| req_idx | input | IDX_W | Requested point index (all ones selects boost) |
| pwr_ok | input | 1 | Power is below budget |
| temp_ok | input | 1 | Temperature is below limit |
| vreg_settled | input | 1 | Regulator reports the new voltage has settled |
| volt_code | output | V_W | Voltage code to the regulator |
| freq_code | output | F_W | Frequency code to the clock generator |
| cur_idx | output | IDX_W | Point index currently in force |
| busy | output | 1 | A move is in progress |

## Verification
The bench builds the block with its default parameters: five regular points behind a 3-bit index, a frequency step of 30 and a voltage step of 20. With these values, index 7 is the boost point and indices 5 and 6 are reachable out-of-range codes. Every point also gets a distinct pair of codes, so each single change of volt_code or freq_code can be matched to exactly one expected step. The bench's regulator model answers each voltage change with a settle pulse three cycles later. This delay is long enough to observe the hold window, and it also lets a second request land while a move is still in flight.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_UP_WAIT = 2'd1,
    SEQ_DN_VOLT = 2'd2,
    SEQ_DN_WAIT = 2'd3
  } seq_state_e;

  // Code for a ladder rank: rank 0 is boost, rank k+1 is regular point k.
  function automatic int point_code(input int top, input int step, input int rank);
    return top - step * rank;
  endfunction

  // Map a request index onto a ladder rank, saturating out-of-range codes.
  function automatic int idx_to_rank(input int idx, input int idx_w, input int num_pts);
    if (idx == (1 << idx_w) - 1) return 0;
    if (idx >= num_pts) return num_pts;
    return idx + 1;
  endfunction

  // Map a ladder rank back onto the external index encoding.
  function automatic int rank_to_idx(input int rank, input int idx_w);
    if (rank == 0) return (1 << idx_w) - 1;
    return rank - 1;
  endfunction

endpackage

// File: rtl/dvfs_req_latch.sv
module dvfs_req_latch #(
  parameter int IDX_W       = 3,
  parameter int NUM_PSTATES = 5,
  parameter int RW          = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  output logic [RW-1:0]    pend_rank
);

  localparam logic [RW-1:0] SLOW_RANK = RW'(NUM_PSTATES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_rank <= SLOW_RANK;
    end else if (req_valid) begin
      pend_rank <= RW'(dvfs_pkg::idx_to_rank(int'(req_idx), IDX_W, NUM_PSTATES));
    end
  end

endmodule

// File: rtl/dvfs_step_fsm.sv
module dvfs_step_fsm #(
  parameter int NUM_PSTATES = 5,
  parameter int RW          = 3,
  parameter int F_W         = 8,
  parameter int V_W         = 8,
  parameter int FREQ_TOP    = 200,
  parameter int FREQ_STEP   = 30,
  parameter int VOLT_TOP    = 220,
  parameter int VOLT_STEP   = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RW-1:0]  eff_rank,
  input  logic           vreg_settled,
  output logic [V_W-1:0] volt_code,
  output logic [F_W-1:0] freq_code,
  output logic [RW-1:0]  cur_rank,
  output logic           busy,
  output logic           start_up,
  output logic           start_dn,
  output logic           wait_up
);

  import dvfs_pkg::*;

  localparam logic [RW-1:0] SLOW_RANK = RW'(NUM_PSTATES);

  seq_state_e    state_q;
  logic [RW-1:0] tgt_q;

  assign busy     = (state_q != SEQ_IDLE);
  assign wait_up  = (state_q == SEQ_UP_WAIT);
  assign start_up = (state_q == SEQ_IDLE) && (eff_rank < cur_rank);
  assign start_dn = (state_q == SEQ_IDLE) && (eff_rank > cur_rank);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      tgt_q     <= SLOW_RANK;
      cur_rank  <= SLOW_RANK;
      volt_code <= V_W'(point_code(VOLT_TOP, VOLT_STEP, NUM_PSTATES));
      freq_code <= F_W'(point_code(FREQ_TOP, FREQ_STEP, NUM_PSTATES));
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_up) begin
            tgt_q     <= eff_rank;
            volt_code <= V_W'(point_code(VOLT_TOP, VOLT_STEP, int'(eff_rank)));
            state_q   <= SEQ_UP_WAIT;
          end else if (start_dn) begin
            tgt_q     <= eff_rank;
            freq_code <= F_W'(point_code(FREQ_TOP, FREQ_STEP, int'(eff_rank)));
            state_q   <= SEQ_DN_VOLT;
          end
        end
        SEQ_UP_WAIT: begin
          if (vreg_settled) begin
            freq_code <= F_W'(point_code(FREQ_TOP, FREQ_STEP, int'(tgt_q)));
            cur_rank  <= tgt_q;
            state_q   <= SEQ_IDLE;
          end
        end
        SEQ_DN_VOLT: begin
          volt_code <= V_W'(point_code(VOLT_TOP, VOLT_STEP, int'(tgt_q)));
          state_q   <= SEQ_DN_WAIT;
        end
        SEQ_DN_WAIT: begin
          if (vreg_settled) begin
            cur_rank <= tgt_q;
            state_q  <= SEQ_IDLE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq #(
  parameter int IDX_W       = 3,
  parameter int NUM_PSTATES = 5,
  parameter int F_W         = 8,
  parameter int V_W         = 8,
  parameter int FREQ_TOP    = 200,
  parameter int FREQ_STEP   = 30,
  parameter int VOLT_TOP    = 220,
  parameter int VOLT_STEP   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             pwr_ok,
  input  logic             temp_ok,
  input  logic             vreg_settled,
  output logic [V_W-1:0]   volt_code,
  output logic [F_W-1:0]   freq_code,
  output logic [IDX_W-1:0] cur_idx,
  output logic             busy
);

  localparam int RW = $clog2(NUM_PSTATES + 1);

  logic [RW-1:0] pend_rank;
  logic [RW-1:0] eff_rank;
  logic [RW-1:0] cur_rank;
  logic          turbo_ok;
  logic          start_up;
  logic          start_dn;
  logic          wait_up;

  dvfs_req_latch #(
    .IDX_W(IDX_W), .NUM_PSTATES(NUM_PSTATES), .RW(RW)
  ) u_req (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_idx(req_idx), .pend_rank(pend_rank)
  );

  // Boost is only a legal target while both permission flags hold.
  assign turbo_ok = pwr_ok & temp_ok;
  assign eff_rank = ((pend_rank == '0) && !turbo_ok) ? RW'(1) : pend_rank;

  dvfs_step_fsm #(
    .NUM_PSTATES(NUM_PSTATES), .RW(RW), .F_W(F_W), .V_W(V_W),
    .FREQ_TOP(FREQ_TOP), .FREQ_STEP(FREQ_STEP),
    .VOLT_TOP(VOLT_TOP), .VOLT_STEP(VOLT_STEP)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .eff_rank(eff_rank),
    .vreg_settled(vreg_settled), .volt_code(volt_code),
    .freq_code(freq_code), .cur_rank(cur_rank), .busy(busy),
    .start_up(start_up), .start_dn(start_dn), .wait_up(wait_up)
  );

  assign cur_idx = IDX_W'(dvfs_pkg::rank_to_idx(int'(cur_rank), IDX_W));

endmodule

// File: rtl/dvfs_seq_chk.sv
module dvfs_seq_chk #(
  parameter int RW  = 3,
  parameter int F_W = 8,
  parameter int V_W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pwr_ok,
  input logic           temp_ok,
  input logic           vreg_settled,
  input logic [V_W-1:0] volt_code,
  input logic [F_W-1:0] freq_code,
  input logic           busy,
  input logic [RW-1:0]  eff_rank,
  input logic [RW-1:0]  cur_rank,
  input logic           start_up,
  input logic           start_dn,
  input logic           wait_up
);

  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  AST_UP_FREQ_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && freq_code > $past(freq_code)) |-> ($past(vreg_settled) && $stable(volt_code))); // R2

  AST_DN_VOLT_AFTER_FREQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && volt_code < $past(volt_code)) |-> ($stable(freq_code) && $past(freq_code) < $past(freq_code, 2))); // R3

  AST_ONE_KNOB_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0) |-> ($stable(freq_code) || $stable(volt_code))); // R3

  AST_HOLD_UNTIL_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_up && !vreg_settled) |=> ($stable(freq_code) && $stable(volt_code) && busy)); // R4

  AST_TURBO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_up && eff_rank == '0) |-> (pwr_ok && temp_ok)); // R5

  AST_TURBO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cur_rank == '0 && !(pwr_ok && temp_ok)) |=> busy); // R6

  AST_MOVE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && !($stable(freq_code) && $stable(volt_code))) |-> (busy || $past(busy))); // R7

  AST_EQUAL_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && eff_rank == cur_rank) |=> ($stable(freq_code) && $stable(volt_code) && !busy)); // R8

  AST_START_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_up, start_dn})); // R2

endmodule

bind dvfs_seq dvfs_seq_chk #(.RW(RW), .F_W(F_W), .V_W(V_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .temp_ok(temp_ok),
  .vreg_settled(vreg_settled), .volt_code(volt_code), .freq_code(freq_code),
  .busy(busy), .eff_rank(eff_rank), .cur_rank(cur_rank),
  .start_up(start_up), .start_dn(start_dn), .wait_up(wait_up)
);

// File: tb/sim_dvfs_seq.sv
`timescale 1ns/1ps
module sim_dvfs_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_idx = 3'd0;
  logic       pwr_ok = 1'b1;
  logic       temp_ok = 1'b1;
  logic       vreg_settled = 1'b0;
  logic [7:0] volt_code;
  logic [7:0] freq_code;
  logic [2:0] cur_idx;
  logic       busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit mon_en = 1'b0;

  logic [15:0] expq[$];
  logic [7:0]  prev_v, prev_f, reg_prev;
  int          reg_cnt = 0;

  always #2.5 clk = ~clk;

  dvfs_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
    .pwr_ok(pwr_ok), .temp_ok(temp_ok), .vreg_settled(vreg_settled),
    .volt_code(volt_code), .freq_code(freq_code), .cur_idx(cur_idx), .busy(busy)
  );

  // Expected codes per ladder rank (rank 0 boost, rank 5 slowest).
  function automatic logic [7:0] fexp(input int r);
    return 8'(50 + 30 * (5 - r));
  endfunction
  function automatic logic [7:0] vexp(input int r);
    return 8'(120 + 20 * (5 - r));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Push the expected sequence of output pairs for one move.
  task automatic push_move(input int from, input int to);
    if (to < from) begin
      expq.push_back({vexp(to), fexp(from)});
      expq.push_back({vexp(to), fexp(to)});
    end else if (to > from) begin
      expq.push_back({vexp(from), fexp(to)});
      expq.push_back({vexp(to), fexp(to)});
    end
  endtask

  task automatic send(input logic [2:0] idx);
    @(negedge clk);
    req_idx = idx;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, req, expq.size(), 0);
  endtask

  // Monitor: each change of the code pair must match the queue head.
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (volt_code != prev_v || freq_code != prev_f) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R2/R3 unexpected step", {volt_code, freq_code}, 0);
        end else begin
          logic [15:0] e;
          e = expq.pop_front();
          chk({volt_code, freq_code} == e, "R2/R3 step order",
              {volt_code, freq_code}, e);
        end
        prev_v = volt_code;
        prev_f = freq_code;
      end
    end
  end

  // Regulator model: settle pulse three cycles after a voltage change.
  always @(negedge clk) begin
    if (!rst_n) begin
      reg_cnt = 0;
      vreg_settled = 1'b0;
    end else begin
      if (volt_code != reg_prev) begin
        reg_prev = volt_code;
        reg_cnt = 4;
      end else if (reg_cnt > 0) begin
        reg_cnt--;
      end
      vreg_settled = (reg_cnt == 1);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    prev_v = volt_code;
    prev_f = freq_code;
    reg_prev = volt_code;
    mon_en = 1'b1;

    // R10: reset state is the slowest regular point
    chk(volt_code == vexp(5), "R10 volt", volt_code, vexp(5));
    chk(freq_code == fexp(5), "R10 freq", freq_code, fexp(5));
    chk(busy == 1'b0, "R10 busy", busy, 0);
    chk(cur_idx == 3'd4, "R10 cur_idx", cur_idx, 4);

    // R2: speed up from point 4 to point 2
    push_move(5, 3);
    send(3'd2);
    wait_idle("R2 queue");
    chk(cur_idx == 3'd2, "R2 cur_idx", cur_idx, 2);
    chk(freq_code == fexp(3), "R1 freq point2", freq_code, fexp(3));

    // R3: slow down back to point 4
    push_move(3, 5);
    send(3'd4);
    wait_idle("R3 queue");
    chk(cur_idx == 3'd4, "R3 cur_idx", cur_idx, 4);

    // R7: request during a move is held and served afterwards
    push_move(5, 1);
    push_move(1, 4);
    send(3'd0);
    @(negedge clk);
    chk(busy == 1'b1, "R7 busy", busy, 1);
    send(3'd3);
    wait_idle("R7 queue");
    chk(cur_idx == 3'd3, "R7 cur_idx", cur_idx, 3);

    // R8: request for the current point changes nothing
    send(3'd3);
    repeat (4) begin
      @(negedge clk);
      chk(busy == 1'b0, "R8 busy", busy, 0);
    end
    chk(volt_code == vexp(4) && freq_code == fexp(4), "R8 codes",
        {volt_code, freq_code}, {vexp(4), fexp(4)});

    // R9: out-of-range index saturates to the slowest point
    push_move(4, 5);
    send(3'd6);
    wait_idle("R9 queue");
    chk(cur_idx == 3'd4, "R9 cur_idx", cur_idx, 4);

    // R5: boost entry with both flags high
    push_move(5, 0);
    send(3'd7);
    wait_idle("R5 queue");
    chk(cur_idx == 3'd7, "R5 cur_idx", cur_idx, 7);
    chk(freq_code == 8'd200 && volt_code == 8'd220, "R1 boost codes",
        {volt_code, freq_code}, {8'd220, 8'd200});

    // R6: temperature flag drops, forced to point 0
    push_move(0, 1);
    @(negedge clk);
    temp_ok = 1'b0;
    wait_idle("R6 queue temp");
    chk(cur_idx == 3'd0, "R6 cur_idx temp", cur_idx, 0);

    // R5: pending boost resumes when flags return
    push_move(1, 0);
    @(negedge clk);
    temp_ok = 1'b1;
    wait_idle("R5 resume queue");
    chk(cur_idx == 3'd7, "R5 resume cur_idx", cur_idx, 7);

    // R6: power flag drops
    push_move(0, 1);
    @(negedge clk);
    pwr_ok = 1'b0;
    wait_idle("R6 queue pwr");
    chk(cur_idx == 3'd0, "R6 cur_idx pwr", cur_idx, 0);

    // R5: boost request with power flag low stays at point 0
    send(3'd7);
    repeat (6) @(negedge clk);
    chk(cur_idx == 3'd0 && busy == 1'b0, "R5 gated", cur_idx, 0);

    // Leave boost request behind: go to point 1
    push_move(1, 2);
    send(3'd1);
    wait_idle("R3 queue p1");
    pwr_ok = 1'b1;
    chk(cur_idx == 3'd1, "R3 cur_idx p1", cur_idx, 1);

    // R4: codes hold between voltage rise and settle
    push_move(2, 1);
    send(3'd0);
    for (int i = 0; i < 10 && volt_code != vexp(1); i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(freq_code == fexp(2), "R4 freq held", freq_code, fexp(2));
    chk(busy == 1'b1, "R4 busy held", busy, 1);
    wait_idle("R4 queue");
    chk(cur_idx == 3'd0, "R4 cur_idx", cur_idx, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule